// File: doc/BRIEF.md
# Register Command Sequencer with Timed Poll

This block steps through a table of configuration steps held in a read-only step memory. It turns each step into one or two transactions on a simple request/acknowledge register-access port. A step is a read, a write, a masked read-modify-write, or a poll. A poll re-reads one register at a fixed spacing until a masked compare matches, or until a time budget runs out. Steps can be tagged as conditional: they run only when the role input selects the slave role and are skipped otherwise. This lets one table hold a common pre-init part, an optional slave-only group and a main init part, always in that order.

A step can also request a settle pause after it completes, for example to let analog circuits recover after a modify step. All times are given in microseconds and turned into clock cycles from a clock-frequency parameter. A single start pulse runs the table from address 0 to the step flagged as last. At the end the block raises either a done flag or an error flag with a cause code, and that flag stays up until the next start.

Top module: `step_sequencer`

## Requirements
- R1: After reset, busy, done, error, bus_req and err_code are all 0.
- R2: A step word packs, from the LSB up: mask [DATA_W], value [DATA_W], offset [OFS_W], bank [BANK_W], settle bit, conditional bit, last bit, and a 2-bit mode (0 read, 1 write, 2 modify, 3 poll). Steps run in address order from 0. After the step with the last bit set completes, done rises.
- R3: A write step issues one write of the step value to the step's bank and offset.
- R4: A read step issues exactly one read and no write.
- R5: A modify step reads the register, then writes value OR (old AND NOT mask) to the same location.
- R6: A poll step completes when (read data AND mask) equals the value. Between two of its reads there are at least POLL_US worth of clock cycles, computed as CLK_HZ/1000*POLL_US/1000.
- R7: If a poll has not matched after TIMEOUT_US worth of cycles, the block stops, sets error with err_code 2 and runs no later step.
- R8: An access acknowledged with bus_err stops the block with error and err_code 1. No later step runs.
- R9: A step with the conditional bit set makes no access when role_slave is 0, and runs normally when role_slave is 1.
- R10: A step with the settle bit set is followed by a pause of at least SETTLE_US worth of cycles before the next access.
- R11: A start pulse while busy is ignored. Done or error holds until the next accepted start, which clears both.
- R12: Once raised, bus_req stays high with stable we, bank, offset and write data until bus_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run pulse, accepted only while idle |
| role_slave | input | 1 | 1 enables the conditional steps |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last step completed without fault |
| error | output | 1 | Sequence aborted |
| err_code | output | 2 | 0 none, 1 bus fault, 2 poll timeout |
| rom_addr | output | ROM_AW | Step address |
| rom_data | input | STEP_W | Step word, valid ROM_LAT cycles after rom_addr |
| bus_req | output | 1 | Access request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_bank | output | BANK_W | Register bank |
| bus_offset | output | OFS_W | Register offset |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, valid with bus_ack |
| bus_ack | input | 1 | Access complete |
| bus_err | input | 1 | Access failed, valid with bus_ack |

## Verification
On every cycle, the assertions check the request handshake, that the idle state issues no request, that busy rises only on a start, and that the done, error and err_code flags hold and exclude one another. The values written by modify steps, the spacing and number of poll re-reads, the timeout and bus-fault aborts, the skipping of conditional steps and the length of the settle pause all depend on register contents and elapsed time. Only the bench scenarios can show these. The bench runs a sweep of old/value/mask triples through the modify path and replays both roles over the same table.

// File: rtl/step_seq_pkg.sv
package step_seq_pkg;

   typedef enum logic [1:0] {
      MODE_RD   = 2'd0,
      MODE_WR   = 2'd1,
      MODE_RMW  = 2'd2,
      MODE_POLL = 2'd3
   } step_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_ISSUE,
      ST_GAP,
      ST_INTERVAL,
      ST_SETTLE
   } seq_state_e;

   localparam logic [1:0] FAULT_NONE    = 2'd0;
   localparam logic [1:0] FAULT_BUS     = 2'd1;
   localparam logic [1:0] FAULT_TIMEOUT = 2'd2;

   // microseconds to clock cycles, staying inside 32 bits for MHz-range clocks
   function automatic int unsigned us_to_cycles(input int unsigned clk_hz,
                                                input int unsigned us);
      return ((clk_hz / 1000) * us) / 1000;
   endfunction

endpackage

// File: rtl/seq_countdown.sv
module seq_countdown #(
   parameter int unsigned CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expired
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/seq_step_alu.sv
module seq_step_alu #(
   parameter int unsigned DATA_W = 16
) (
   input  logic [DATA_W-1:0] rd_val,
   input  logic [DATA_W-1:0] step_val,
   input  logic [DATA_W-1:0] step_mask,
   output logic [DATA_W-1:0] merged,
   output logic              poll_hit
);
   // keep the bits outside the mask, OR in the new value
   assign merged   = step_val | (rd_val & ~step_mask);
   assign poll_hit = ((rd_val & step_mask) == step_val);
endmodule

// File: rtl/step_sequencer.sv
module step_sequencer
   import step_seq_pkg::*;
#(
   parameter int unsigned BANK_W     = 3,
   parameter int unsigned OFS_W      = 8,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned ROM_AW     = 6,
   parameter int unsigned ROM_LAT    = 0,
   parameter int unsigned CLK_HZ     = 25_000_000,
   parameter int unsigned POLL_US    = 150,
   parameter int unsigned TIMEOUT_US = 30_000,
   parameter int unsigned SETTLE_US  = 50_000,
   localparam int unsigned STEP_W    = 2 * DATA_W + OFS_W + BANK_W + 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              role_slave,
   output logic              busy,
   output logic              done,
   output logic              error,
   output logic [1:0]        err_code,
   output logic [ROM_AW-1:0] rom_addr,
   input  logic [STEP_W-1:0] rom_data,
   output logic              bus_req,
   output logic              bus_we,
   output logic [BANK_W-1:0] bus_bank,
   output logic [OFS_W-1:0]  bus_offset,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_ack,
   input  logic              bus_err
);
   // step word layout
   localparam int unsigned MASK_LO    = 0;
   localparam int unsigned VAL_LO     = DATA_W;
   localparam int unsigned OFS_LO     = 2 * DATA_W;
   localparam int unsigned BANK_LO    = OFS_LO + OFS_W;
   localparam int unsigned SETTLE_BIT = BANK_LO + BANK_W;
   localparam int unsigned COND_BIT   = SETTLE_BIT + 1;
   localparam int unsigned LAST_BIT   = SETTLE_BIT + 2;
   localparam int unsigned MODE_LO    = SETTLE_BIT + 3;

   localparam int unsigned IVL_CYC = us_to_cycles(CLK_HZ, POLL_US);
   localparam int unsigned TMO_CYC = us_to_cycles(CLK_HZ, TIMEOUT_US);
   localparam int unsigned SET_CYC = us_to_cycles(CLK_HZ, SETTLE_US);
   localparam int unsigned IVL_W   = $clog2(IVL_CYC + 1);
   localparam int unsigned TMO_W   = $clog2(TMO_CYC + 1);
   localparam int unsigned SET_W   = $clog2(SET_CYC + 1);

   // elaboration checks
   if (BANK_W < 1 || OFS_W < 1 || DATA_W < 1 || ROM_AW < 1) begin : g_bad_width
      $error("step_sequencer: widths must be at least 1");
   end
   if (ROM_LAT > 1) begin : g_bad_lat
      $error("step_sequencer: ROM_LAT must be 0 or 1");
   end
   if (IVL_CYC < 1 || TMO_CYC <= IVL_CYC || SET_CYC < 1) begin : g_bad_time
      $error("step_sequencer: timing parameters give too few cycles");
   end

   seq_state_e        state_q;
   logic [ROM_AW-1:0] pc_q;
   step_mode_e        cur_mode_q;
   logic              cur_last_q;
   logic              cur_settle_q;
   logic [BANK_W-1:0] cur_bank_q;
   logic [OFS_W-1:0]  cur_ofs_q;
   logic [DATA_W-1:0] cur_val_q;
   logic [DATA_W-1:0] cur_mask_q;
   logic              we_q;
   logic [DATA_W-1:0] wdata_q;
   logic              done_q;
   logic              error_q;
   logic [1:0]        code_q;

   // step memory access variants
   logic in_fetch;
   logic rom_ok;
   assign in_fetch = (state_q == ST_FETCH);

   if (ROM_LAT == 0) begin : g_rom_comb
      assign rom_ok = in_fetch;
   end else begin : g_rom_reg
      logic primed_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            primed_q <= 1'b0;
         else
            primed_q <= in_fetch && !primed_q;
      end
      assign rom_ok = in_fetch && primed_q;
   end

   // fields of the step being fetched
   step_mode_e rom_mode;
   logic       rom_cond;
   logic       rom_last;
   assign rom_mode = step_mode_e'(rom_data[MODE_LO +: 2]);
   assign rom_cond = rom_data[COND_BIT];
   assign rom_last = rom_data[LAST_BIT];

   // data path
   logic [DATA_W-1:0] merged;
   logic              poll_hit;

   seq_step_alu #(.DATA_W(DATA_W)) u_alu (
      .rd_val    (bus_rdata),
      .step_val  (cur_val_q),
      .step_mask (cur_mask_q),
      .merged    (merged),
      .poll_hit  (poll_hit)
   );

   // step control decode
   logic skip, launch, acc_done, step_ok, rmw_turn, poll_miss;
   logic ivl_load, tmo_load, set_load, step_end, end_last;
   logic ivl_exp, tmo_exp, set_exp;

   always_comb begin
      skip      = rom_ok && rom_cond && !role_slave;
      launch    = rom_ok && !(rom_cond && !role_slave);
      acc_done  = (state_q == ST_ISSUE) && bus_ack && !bus_err;
      step_ok   = acc_done && ((cur_mode_q == MODE_WR) || (cur_mode_q == MODE_RD) ||
                               ((cur_mode_q == MODE_RMW) && we_q) ||
                               ((cur_mode_q == MODE_POLL) && poll_hit));
      rmw_turn  = acc_done && (cur_mode_q == MODE_RMW) && !we_q;
      poll_miss = acc_done && (cur_mode_q == MODE_POLL) && !poll_hit;
      ivl_load  = poll_miss && !tmo_exp;
      tmo_load  = launch && (rom_mode == MODE_POLL);
      set_load  = step_ok && cur_settle_q;
      step_end  = skip || (step_ok && !cur_settle_q) ||
                  ((state_q == ST_SETTLE) && set_exp);
      end_last  = skip ? rom_last : cur_last_q;
   end

   seq_countdown #(.CW(IVL_W)) u_ivl (
      .clk(clk), .rst_n(rst_n), .load(ivl_load),
      .load_val(IVL_W'(IVL_CYC)), .expired(ivl_exp)
   );

   seq_countdown #(.CW(TMO_W)) u_tmo (
      .clk(clk), .rst_n(rst_n), .load(tmo_load),
      .load_val(TMO_W'(TMO_CYC)), .expired(tmo_exp)
   );

   seq_countdown #(.CW(SET_W)) u_set (
      .clk(clk), .rst_n(rst_n), .load(set_load),
      .load_val(SET_W'(SET_CYC)), .expired(set_exp)
   );

   // step state machine
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         pc_q         <= '0;
         cur_mode_q   <= MODE_RD;
         cur_last_q   <= 1'b0;
         cur_settle_q <= 1'b0;
         cur_bank_q   <= '0;
         cur_ofs_q    <= '0;
         cur_val_q    <= '0;
         cur_mask_q   <= '0;
         we_q         <= 1'b0;
         wdata_q      <= '0;
         done_q       <= 1'b0;
         error_q      <= 1'b0;
         code_q       <= FAULT_NONE;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  pc_q    <= '0;
                  done_q  <= 1'b0;
                  error_q <= 1'b0;
                  code_q  <= FAULT_NONE;
                  state_q <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (launch) begin
                  cur_mode_q   <= rom_mode;
                  cur_last_q   <= rom_last;
                  cur_settle_q <= rom_data[SETTLE_BIT];
                  cur_bank_q   <= rom_data[BANK_LO +: BANK_W];
                  cur_ofs_q    <= rom_data[OFS_LO +: OFS_W];
                  cur_val_q    <= rom_data[VAL_LO +: DATA_W];
                  cur_mask_q   <= rom_data[MASK_LO +: DATA_W];
                  wdata_q      <= rom_data[VAL_LO +: DATA_W];
                  we_q         <= (rom_mode == MODE_WR);
                  state_q      <= ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               if (bus_ack && bus_err) begin
                  error_q <= 1'b1;
                  code_q  <= FAULT_BUS;
                  state_q <= ST_IDLE;
               end else if (rmw_turn) begin
                  wdata_q <= merged;
                  we_q    <= 1'b1;
                  state_q <= ST_GAP;
               end else if (poll_miss) begin
                  if (tmo_exp) begin
                     error_q <= 1'b1;
                     code_q  <= FAULT_TIMEOUT;
                     state_q <= ST_IDLE;
                  end else begin
                     state_q <= ST_INTERVAL;
                  end
               end else if (set_load) begin
                  state_q <= ST_SETTLE;
               end
            end
            ST_GAP: state_q <= ST_ISSUE;
            ST_INTERVAL: begin
               if (tmo_exp) begin
                  error_q <= 1'b1;
                  code_q  <= FAULT_TIMEOUT;
                  state_q <= ST_IDLE;
               end else if (ivl_exp) begin
                  state_q <= ST_ISSUE;
               end
            end
            default: ;
         endcase

         if (step_end) begin
            if (end_last) begin
               done_q  <= 1'b1;
               state_q <= ST_IDLE;
            end else begin
               pc_q    <= pc_q + 1'b1;
               state_q <= ST_FETCH;
            end
         end
      end
   end

   assign busy       = (state_q != ST_IDLE);
   assign done       = done_q;
   assign error      = error_q;
   assign err_code   = code_q;
   assign rom_addr   = pc_q;
   assign bus_req    = (state_q == ST_ISSUE);
   assign bus_we     = we_q;
   assign bus_bank   = cur_bank_q;
   assign bus_offset = cur_ofs_q;
   assign bus_wdata  = wdata_q;
endmodule

// File: rtl/step_sequencer_chk.sv
module step_sequencer_chk #(
   parameter int unsigned BANK_W = 3,
   parameter int unsigned OFS_W  = 8,
   parameter int unsigned DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic              error,
   input logic [1:0]        err_code,
   input logic              bus_req,
   input logic              bus_ack,
   input logic              bus_we,
   input logic [BANK_W-1:0] bus_bank,
   input logic [OFS_W-1:0]  bus_offset,
   input logic [DATA_W-1:0] bus_wdata
);
   assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_bank) &&
                              $stable(bus_offset) && $stable(bus_wdata));

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !bus_req);

   assert_start_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   assert_done_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> done);

   assert_error_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      error && !start |=> error && $stable(err_code));

   assert_flags_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !done && !error);

   assert_code_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
      error == (err_code != 2'd0));

   assert_end_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (done != error));
endmodule

bind step_sequencer step_sequencer_chk #(
   .BANK_W(BANK_W), .OFS_W(OFS_W), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .error(error), .err_code(err_code), .bus_req(bus_req), .bus_ack(bus_ack),
   .bus_we(bus_we), .bus_bank(bus_bank), .bus_offset(bus_offset),
   .bus_wdata(bus_wdata)
);

// File: tb/step_sequencer_tb.sv
module step_sequencer_tb;
   localparam int CLK_PERIOD = 10;
   localparam int BANK_W = 3, OFS_W = 8, DATA_W = 16, ROM_AW = 6;
   localparam int CLK_HZ = 100_000;
   localparam int IVL = 15, TMO = 3000, SET = 5000;   // 150 us, 30 ms, 50 ms at 100 kHz
   localparam int STEP_W = 2 * DATA_W + OFS_W + BANK_W + 5;
   localparam int LOGN = 512;

   logic clk = 0, rst_n = 0, start = 0, role_slave = 0;
   logic busy, done, error;
   logic [1:0] err_code;
   logic [ROM_AW-1:0] rom_addr;
   logic [STEP_W-1:0] rom_data;
   logic bus_req, bus_we, bus_ack, bus_err;
   logic [BANK_W-1:0] bus_bank;
   logic [OFS_W-1:0] bus_offset;
   logic [DATA_W-1:0] bus_wdata, bus_rdata;

   logic [STEP_W-1:0] rom [0:63];
   assign rom_data = rom[rom_addr];

   always #(CLK_PERIOD/2) clk = ~clk;

   step_sequencer #(
      .BANK_W(BANK_W), .OFS_W(OFS_W), .DATA_W(DATA_W), .ROM_AW(ROM_AW),
      .ROM_LAT(0), .CLK_HZ(CLK_HZ), .POLL_US(150), .TIMEOUT_US(30_000),
      .SETTLE_US(50_000)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .role_slave(role_slave),
      .busy(busy), .done(done), .error(error), .err_code(err_code),
      .rom_addr(rom_addr), .rom_data(rom_data),
      .bus_req(bus_req), .bus_we(bus_we), .bus_bank(bus_bank),
      .bus_offset(bus_offset), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_ack(bus_ack), .bus_err(bus_err)
   );

   // register target model with access log
   logic [DATA_W-1:0] mem [0:7][0:255];
   int cyc = 0;
   int log_n = 0;
   logic log_we [0:LOGN-1];
   logic [BANK_W-1:0] log_bank [0:LOGN-1];
   logic [OFS_W-1:0] log_off [0:LOGN-1];
   int log_cyc [0:LOGN-1];
   int bad_bank = 8;
   logic [BANK_W-1:0] pbank = 0;
   logic [OFS_W-1:0] poff = 0;
   int flip_n = 0, pcount = 0;
   logic [DATA_W-1:0] flip_val = 0;
   logic pre_go = 0, clr_go = 0;
   logic [BANK_W-1:0] pre_bank = 0;
   logic [OFS_W-1:0] pre_off = 0;
   logic [DATA_W-1:0] pre_val = 0;

   initial begin
      for (int b = 0; b < 8; b++)
         for (int o = 0; o < 256; o++) mem[b][o] = '0;
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (pre_go) mem[pre_bank][pre_off] <= pre_val;
      if (clr_go) begin log_n <= 0; pcount <= 0; end
      if (!rst_n) begin
         bus_ack <= 0; bus_err <= 0; bus_rdata <= '0;
      end else if (bus_req && !bus_ack) begin
         bus_ack <= 1'b1;
         bus_err <= (int'(bus_bank) == bad_bank);
         if (log_n < LOGN) begin
            log_we[log_n] <= bus_we; log_bank[log_n] <= bus_bank;
            log_off[log_n] <= bus_offset; log_cyc[log_n] <= cyc;
            log_n <= log_n + 1;
         end
         if (int'(bus_bank) != bad_bank) begin
            if (bus_we) mem[bus_bank][bus_offset] <= bus_wdata;
            else begin
               bus_rdata <= mem[bus_bank][bus_offset];
               if (bus_bank == pbank && bus_offset == poff) begin
                  pcount <= pcount + 1;
                  if (pcount + 1 == flip_n) mem[pbank][poff] <= flip_val;
               end
            end
         end
      end else begin
         bus_ack <= 0; bus_err <= 0;
      end
   end

   int checks = 0, errors = 0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                        input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic check_range(input string req, input int act, input int lo, input int hi,
                              input string what);
      checks++;
      if (act < lo || act > hi) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
      end
   endtask

   function automatic logic [STEP_W-1:0] mk(input int mode, input bit last, input bit cond,
                                            input bit settle, input int bank, input int off,
                                            input int val, input int mask);
      logic [STEP_W-1:0] w;
      w = '0;
      w[15:0]  = val[15:0] == val[15:0] ? mask[15:0] : '0;
      w[31:16] = val[15:0];
      w[39:32] = off[7:0];
      w[42:40] = bank[2:0];
      w[43] = settle; w[44] = cond; w[45] = last;
      w[47:46] = mode[1:0];
      return w;
   endfunction

   task automatic preload(input int b, input int o, input int v);
      @(negedge clk);
      pre_bank = b[2:0]; pre_off = o[7:0]; pre_val = v[15:0]; pre_go = 1;
      @(negedge clk); pre_go = 0;
   endtask

   task automatic clear_log();
      @(negedge clk); clr_go = 1; @(negedge clk); clr_go = 0;
   endtask

   task automatic pulse_start(input bit slave);
      @(negedge clk); role_slave = slave; start = 1;
      @(negedge clk); start = 0;
   endtask

   task automatic wait_end(output int cycles);
      cycles = 0;
      while (!(done || error) && cycles < 60000) begin
         @(negedge clk); cycles++;
      end
   endtask

   localparam int RD = 0, WR = 1, MD = 2, PL = 3;

   task automatic load_main_table();
      rom[0] = mk(WR, 0, 0, 0, 1, 10, 16'h1234, 0);
      rom[1] = mk(WR, 0, 0, 0, 2, 20, 16'hABCD, 0);
      rom[2] = mk(WR, 0, 1, 0, 4, 30, 16'h7777, 0);
      rom[3] = mk(WR, 0, 1, 0, 4, 31, 16'h8888, 0);
      rom[4] = mk(MD, 0, 0, 0, 3, 5, 16'h0005, 16'h0007);
      rom[5] = mk(RD, 0, 0, 0, 1, 10, 0, 0);
      rom[6] = mk(WR, 1, 0, 0, 0, 1, 16'h0042, 0);
   endtask

   initial begin
      int cycles, reads, prev, t0;
      bit gap_ok;
      for (int i = 0; i < 64; i++) rom[i] = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", busy, 0, "busy in reset");
      check("R1", {done, error, err_code}, 0, "flags in reset");
      check("R1", bus_req, 0, "bus_req in reset");
      rst_n = 1;
      @(negedge clk);
      check("R1", {busy, done, error, bus_req}, 0, "idle after reset");

      // master role: conditional steps skipped
      load_main_table();
      preload(3, 5, 16'hFFF0);
      clear_log();
      pulse_start(0);
      check("R11", {busy, done, error}, 3'b100, "flags after accepted start");
      wait_end(cycles);
      check("R2", {done, error}, 2'b10, "master run ends done");
      check("R3", mem[1][10], 16'h1234, "write step data");
      check("R3", mem[2][20], 16'hABCD, "second write step data");
      check("R9", mem[4][30], 16'h0000, "conditional step skipped as master");
      check("R9", log_n, 6, "access count as master");
      check("R5", {log_we[2], log_we[3], 5'(log_bank[3]), log_off[3]}, {2'b01, 5'd3, 8'd5},
            "modify read then write");
      check("R5", mem[3][5], 16'hFFF5, "modify result");
      check("R4", {log_we[4], 3'(log_bank[4]), log_off[4]}, {1'b0, 3'd1, 8'd10}, "read step access");
      check("R4", mem[1][10], 16'h1234, "read step leaves register");
      check("R2", mem[0][1], 16'h0042, "last step executed");
      repeat (10) @(negedge clk);
      check("R11", {done, busy}, 2'b10, "done holds while idle");

      // slave role: conditional steps run in place
      preload(3, 5, 16'hFFF0);
      clear_log();
      pulse_start(1);
      wait_end(cycles);
      check("R9", {done, error}, 2'b10, "slave run ends done");
      check("R9", log_n, 8, "access count as slave");
      check("R9", {log_we[2], 3'(log_bank[2]), log_off[2]}, {1'b1, 3'd4, 8'd30}, "conditional order");
      check("R9", mem[4][31], 16'h8888, "conditional write as slave");

      // modify sweep
      for (int k = 0; k < 8; k++) begin
         logic [15:0] oldv, val, msk, expv;
         oldv = 16'hA5C3 ^ (16'h1111 * k[15:0]);
         val  = (16'h0203 * k[15:0]) ^ 16'h0810;
         msk  = (16'h00FF << k) ^ 16'h3000;
         expv = val | (oldv & ~msk);
         rom[0] = mk(MD, 1, 0, 0, 5, k, val, msk);
         preload(5, k, oldv);
         pulse_start(0);
         wait_end(cycles);
         check("R5", mem[5][k], expv, $sformatf("modify sweep %0d", k));
      end

      // poll completes after the fourth read
      rom[0] = mk(PL, 0, 0, 0, 2, 7, 16'h0000, 16'h0080);
      rom[1] = mk(WR, 1, 0, 0, 6, 2, 16'h00AA, 0);
      preload(2, 7, 16'h0080);
      pbank = 2; poff = 7; flip_n = 3; flip_val = 16'h0014;
      clear_log();
      pulse_start(0);
      wait_end(cycles);
      check("R6", {done, error}, 2'b10, "poll run ends done");
      check("R6", log_n, 5, "poll read count plus write");
      gap_ok = 1;
      for (int i = 1; i < 4; i++)
         if (log_cyc[i] - log_cyc[i-1] < IVL) gap_ok = 0;
      check("R6", gap_ok, 1, "poll re-read spacing");
      check("R6", mem[6][2], 16'h00AA, "step after poll");

      // poll timeout
      rom[1] = mk(WR, 1, 0, 0, 6, 3, 16'h00BB, 0);
      preload(2, 7, 16'h0080);
      flip_n = 0;
      clear_log();
      t0 = cyc;
      pulse_start(0);
      wait_end(cycles);
      check("R7", {done, error, err_code}, {2'b01, 2'd2}, "timeout fault");
      check("R7", mem[6][3], 16'h0000, "no step after timeout");
      check_range("R7", cyc - t0, TMO, TMO + 60, "cycles to timeout");
      reads = log_n;
      check_range("R7", reads, TMO / (IVL + 4), TMO / IVL + 1, "reads during timeout");

      // bus fault
      rom[0] = mk(WR, 0, 0, 0, 1, 40, 16'h1111, 0);
      rom[1] = mk(WR, 0, 0, 0, 7, 0, 16'h2222, 0);
      rom[2] = mk(WR, 1, 0, 0, 1, 41, 16'h3333, 0);
      bad_bank = 7;
      clear_log();
      pulse_start(0);
      wait_end(cycles);
      check("R8", {done, error, err_code}, {2'b01, 2'd1}, "bus fault");
      check("R8", mem[1][41], 16'h0000, "no step after bus fault");
      check("R8", log_n, 2, "accesses before abort");
      bad_bank = 8;
      repeat (5) @(negedge clk);
      check("R11", {error, err_code}, {1'b1, 2'd1}, "error holds while idle");

      // settle pause and ignored start
      rom[0] = mk(MD, 0, 0, 1, 3, 6, 16'h0010, 16'h0030);
      rom[1] = mk(WR, 1, 0, 0, 3, 7, 16'h0055, 0);
      clear_log();
      pulse_start(0);
      check("R11", {busy, error, err_code}, {1'b1, 1'b0, 2'd0}, "start clears error");
      prev = 0;
      while (log_n < 2 && prev < 100) begin @(negedge clk); prev++; end
      repeat (100) @(negedge clk);
      pulse_start(1);
      wait_end(cycles);
      check("R11", {done, error}, 2'b10, "run with ignored start ends done");
      check("R11", log_n, 3, "start while busy caused no restart");
      check_range("R10", log_cyc[2] - log_cyc[1], SET, SET + 10, "settle pause");
      check("R10", mem[3][7], 16'h0055, "step after settle");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule